// File: doc/BRIEF.md
# Retained Low-Memory RAM with Bus Steering

This block is a 128-byte scratch memory for an 8-bit processor. It sits at the very bottom of a 16-bit address space and is fully decoded, so only addresses 0x0000 through 0x007F reach it. When the processor makes a valid access in that window and the separate RAM-enable level is high, the block serves the access itself. It raises a select flag so that any external memory in the same range stays off the bus. It also asserts the data-bus output-enable, so that no outside data can enter during the access.

Power loss is modelled by a supply-good flag. Only the lowest 32 bytes sit on the standby supply and survive a loss of main power. The upper 96 bytes lose their contents: from then on they return a fixed poison byte (0xFF) until software writes them again.

A correct power-down lowers RAM-enable at least three clock (E) cycles before the supply drops. When the supply drops sooner, the block latches a sticky sequence-error flag and treats the retained bytes as lost too. The clock `clk` stands for E. A write is taken on the clock edge that ends the cycle. Read data is valid combinationally during the cycle.

Top module: `lowmem_ret_ram`

## Requirements
- R1: `int_sel` is 1 exactly when `vma` is 1, `ram_en` is 1 and `addr` is in 0x0000..0x007F; any address from 0x0080 upward never selects.
- R2: A write (`rd_wr`=0) to a selected address is taken at the next rising `clk` edge; a later read (`rd_wr`=1) of that address returns the written byte.
- R3: With `ram_en` at 0 there is no select, `rdata` stays 0x00, and a write to an in-window address leaves the stored byte unchanged.
- R4: `dbus_oe` is 1 during any selected access, read or write, and during any valid external write; it is 0 during a valid external read and when `vma` is 0.
- R5: After reset every byte reads as 0xFF and `seq_err` is 0.
- R6: Once the edge that samples `supply_ok`=0 has passed, bytes 0x20..0x7F read 0xFF until each is written again after the supply returns. Bytes 0x00..0x1F keep their values.
- R7: While `supply_ok` is 0, writes to 0x20..0x7F have no effect (the byte still reads 0xFF), and writes to 0x00..0x1F work normally.
- R8: If `ram_en` was sampled 0 on at least 3 rising edges before the edge that first samples `supply_ok` at 0, `seq_err` stays 0 and bytes 0x00..0x1F are retained.
- R9: If the supply falls with fewer than 3 such edges, or with `ram_en` at 1, `seq_err` becomes 1 after that edge and stays 1 until reset, and bytes 0x00..0x1F also read 0xFF until rewritten.
- R10: `rdata` is 0x00 in every cycle that is not a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock (E); writes are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| rd_wr | input | 1 | 1 = read, 0 = write |
| vma | input | 1 | Address on `addr` is valid this cycle |
| ram_en | input | 1 | Enables the internal RAM; low also arms a power-down |
| supply_ok | input | 1 | Main supply good; 0 models loss of main power |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data, 0x00 when not a selected read |
| int_sel | output | 1 | Internal access in progress; external memory must stay off |
| dbus_oe | output | 1 | Data bus driven by this side (output mode) |
| seq_err | output | 1 | Sticky: supply fell without the required enable lead time |

## Verification
A wrong per-byte valid bit appears on the very next read of that byte: a byte wrongly kept valid returns stale data instead of 0xFF, and a byte wrongly cleared returns 0xFF instead of its data. So every byte is read back across whole-memory sweeps after reset, after a clean power-down and after a violating one. A lead-time counter that is off by one shows up as `seq_err` set, or left clear, one cycle after the supply edge. The bench therefore steps the lead time exactly to the 2-edge and 3-edge boundary. Decode errors show at once, in the same cycle, on `int_sel` and `dbus_oe` at the window edges 0x007F and 0x0080.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  // Address falls inside the internal window [0, depth)
  function automatic logic in_window(input logic [31:0] a, input int unsigned depth);
    return a < depth;
  endfunction

  // Byte index lies in the region fed by the standby supply
  function automatic bit is_kept(input int unsigned idx, input int unsigned keep);
    return idx < keep;
  endfunction

  // Lead time satisfied: enough low-enable edges counted
  function automatic logic lead_ok(input int unsigned cnt, input int unsigned guard);
    return cnt >= guard;
  endfunction

endpackage

// File: rtl/lmr_decode.sv
module lmr_decode #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 128,
  parameter int IDX_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              vma,
  input  logic              rd_wr,
  input  logic              ram_en,
  output logic              hit,
  output logic              hit_rd,
  output logic              hit_wr,
  output logic              drive_bus,
  output logic [IDX_W-1:0]  idx
);
  logic in_range;

  assign in_range  = lmr_pkg::in_window(32'(addr), DEPTH);
  assign hit       = vma & ram_en & in_range;
  assign hit_rd    = hit & rd_wr;
  assign hit_wr    = hit & ~rd_wr;
  assign drive_bus = hit | (vma & ~rd_wr);
  assign idx       = addr[IDX_W-1:0];
endmodule

// File: rtl/lmr_seqmon.sv
module lmr_seqmon #(
  parameter int GUARD_CYC = 3,
  parameter int CNT_W     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ram_en,
  input  logic supply_ok,
  output logic supply_fall,
  output logic seq_violation,
  output logic seq_err
);
  logic [CNT_W-1:0] lead_cnt;
  logic             supply_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt <= '0;
    end else if (ram_en) begin
      lead_cnt <= '0;
    end else if (!lmr_pkg::lead_ok(32'(lead_cnt), GUARD_CYC)) begin
      lead_cnt <= lead_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) supply_q <= 1'b0;
    else        supply_q <= supply_ok;
  end

  assign supply_fall   = supply_q & ~supply_ok;
  assign seq_violation = supply_fall &
                         (ram_en | ~lmr_pkg::lead_ok(32'(lead_cnt), GUARD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seq_err <= 1'b0;
    else if (seq_violation) seq_err <= 1'b1;
  end
endmodule

// File: rtl/lmr_store.sv
module lmr_store #(
  parameter int                DATA_W     = 8,
  parameter int                DEPTH      = 128,
  parameter int                IDX_W      = 7,
  parameter int                KEEP_BYTES = 32,
  parameter logic [DATA_W-1:0] POISON     = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              kill_keep,
  input  logic              kill_upper,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam bit KEPT = lmr_pkg::is_kept(g, KEEP_BYTES);
    logic kill;
    logic vbit;

    if (KEPT) begin : g_kept
      assign kill = kill_keep;
    end else begin : g_lost
      assign kill = kill_upper;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   vbit <= 1'b0;
      else if (kill)                                vbit <= 1'b0;
      else if (wr_en && idx == IDX_W'(g))           vbit <= 1'b1;
    end

    assign valid[g] = vbit;
  end

  assign rdata = !rd_en      ? '0 :
                 valid[idx]  ? mem[idx] : POISON;
endmodule

// File: rtl/lowmem_ret_ram.sv
module lowmem_ret_ram #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 128,
  parameter int KEEP_BYTES = 32,
  parameter int GUARD_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_wr,
  input  logic              vma,
  input  logic              ram_en,
  input  logic              supply_ok,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              int_sel,
  output logic              dbus_oe,
  output logic              seq_err
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(GUARD_CYC + 1);

  // Named internal events, visible to the bound checker
  logic             hit;
  logic             hit_rd;
  logic             hit_wr;
  logic             drive_bus;
  logic [IDX_W-1:0] idx;
  logic             supply_fall;
  logic             seq_violation;

  lmr_decode #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_decode (
    .addr(addr), .vma(vma), .rd_wr(rd_wr), .ram_en(ram_en),
    .hit(hit), .hit_rd(hit_rd), .hit_wr(hit_wr),
    .drive_bus(drive_bus), .idx(idx)
  );

  lmr_seqmon #(
    .GUARD_CYC(GUARD_CYC), .CNT_W(CNT_W)
  ) u_seqmon (
    .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .supply_ok(supply_ok),
    .supply_fall(supply_fall), .seq_violation(seq_violation), .seq_err(seq_err)
  );

  lmr_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
    .KEEP_BYTES(KEEP_BYTES), .POISON('1)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(hit_wr), .rd_en(hit_rd),
    .idx(idx), .wdata(wdata),
    .kill_keep(seq_violation), .kill_upper(~supply_ok),
    .rdata(rdata)
  );

  assign int_sel = hit;
  assign dbus_oe = drive_bus;
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 128,
  parameter int KEEP_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_wr,
  input logic              vma,
  input logic              ram_en,
  input logic              supply_ok,
  input logic [DATA_W-1:0] rdata,
  input logic              int_sel,
  input logic              dbus_oe,
  input logic              seq_err,
  input logic              supply_fall,
  input logic              seq_violation
);
  logic upper_addr;
  assign upper_addr = (32'(addr) >= KEEP_BYTES) && (32'(addr) < DEPTH);

  AST_NO_SEL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en |-> !int_sel);                                           // R3
  AST_NO_SEL_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(addr) >= DEPTH) |-> !int_sel);                              // R1
  AST_OE_COVERS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> dbus_oe);                                            // R4
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vma |-> !dbus_oe);                                              // R4
  AST_QUIET_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_sel && rd_wr) |-> rdata == '0);                            // R10
  AST_UPPER_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(supply_ok) && !supply_ok && int_sel && rd_wr && upper_addr)
      |-> rdata == '1);                                              // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);                                            // R9
  AST_ERR_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_violation |-> supply_fall);                                  // R9
  AST_ERR_ON_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    seq_violation |=> seq_err);                                      // R9
endmodule

bind lowmem_ret_ram lmr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .KEEP_BYTES(KEEP_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr(rd_wr), .vma(vma),
  .ram_en(ram_en), .supply_ok(supply_ok), .rdata(rdata), .int_sel(int_sel),
  .dbus_oe(dbus_oe), .seq_err(seq_err), .supply_fall(supply_fall),
  .seq_violation(seq_violation)
);

// File: tb/lowmem_ret_ram_tb.sv
module lowmem_ret_ram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd_wr = 1'b1;
  logic        vma = 1'b0;
  logic        ram_en = 1'b1;
  logic        supply_ok = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        int_sel;
  logic        dbus_oe;
  logic        seq_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_mem [128];
  bit         exp_val [128];

  always #2.5 clk = ~clk;

  lowmem_ret_ram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr(rd_wr), .vma(vma),
    .ram_en(ram_en), .supply_ok(supply_ok), .wdata(wdata),
    .rdata(rdata), .int_sel(int_sel), .dbus_oe(dbus_oe), .seq_err(seq_err)
  );

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 37 + salt * 11 + 5) & 8'hFF);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic invalidate(input int lo, input int hi);
    for (int i = lo; i < hi; i++) exp_val[i] = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; vma = 1'b1; rd_wr = 1'b0; wdata = d;
    @(posedge clk);
    #1;
    vma = 1'b0; rd_wr = 1'b1;
    if (ram_en && a < 16'h80 && (a < 16'h20 || supply_ok)) begin
      exp_mem[a[6:0]] = d;
      exp_val[a[6:0]] = 1'b1;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [7:0] e;
    logic       sel;
    @(negedge clk);
    addr = a; vma = 1'b1; rd_wr = 1'b1;
    #1;
    sel = ram_en && a < 16'h80;
    e = !sel ? 8'h00 : (exp_val[a[6:0]] ? exp_mem[a[6:0]] : 8'hFF);
    check(tag, rdata, e);
    check({tag, " sel"}, {7'b0, int_sel}, {7'b0, sel});
    vma = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 128; i++) do_read(16'(i), tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vma = 1'b0; rd_wr = 1'b1; ram_en = 1'b1; supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    invalidate(0, 128);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk); #1;
    check("R5 seq_err after reset", {7'b0, seq_err}, 8'h00);
    sweep("R5 poison after reset");

    // R2: fill and read back whole memory
    for (int i = 0; i < 128; i++) do_write(16'(i), pat(i, 0));
    sweep("R2 readback");

    // R1 / R4 / R10: decode window edges and bus direction
    begin
      logic [15:0] probes [8] = '{16'h0000, 16'h001F, 16'h007F, 16'h0080,
                                  16'h00FF, 16'h0100, 16'h8000, 16'hFFFF};
      for (int p = 0; p < 8; p++) begin
        for (int m = 0; m < 4; m++) begin
          logic in_w;
          @(negedge clk);
          addr = probes[p]; vma = m[1]; rd_wr = m[0];
          #1;
          in_w = m[1] && probes[p] < 16'h80;
          check("R1 int_sel decode", {7'b0, int_sel}, {7'b0, in_w});
          check("R4 dbus_oe", {7'b0, dbus_oe}, {7'b0, in_w | (m[1] & ~m[0])});
          if (!(in_w && m[0])) check("R10 quiet rdata", rdata, 8'h00);
          vma = 1'b0; rd_wr = 1'b1;
        end
      end
    end

    // R3: RAM disabled
    @(negedge clk); ram_en = 1'b0;
    do_read(16'h0010, "R3 disabled read");
    do_write(16'h0010, 8'hAA);
    do_write(16'h0050, 8'hAB);
    @(negedge clk); ram_en = 1'b1;
    do_read(16'h0010, "R3 write ignored low");
    do_read(16'h0050, "R3 write ignored high");

    // R8: clean power-down with exactly 3 edges of lead time
    @(negedge clk); ram_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); supply_ok = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    check("R8 no error at 3-edge lead", {7'b0, seq_err}, 8'h00);
    invalidate(32, 128);
    ram_en = 1'b1;
    sweep("R6 R8 after clean loss");

    // R7: writes while supply is down
    do_write(16'h0040, 8'h12);
    do_read(16'h0040, "R7 upper write ignored");
    do_write(16'h0005, 8'h34);
    do_read(16'h0005, "R7 lower write works");

    // R6: supply back, upper stays poison until rewritten
    @(negedge clk); supply_ok = 1'b1;
    repeat (2) @(posedge clk);
    do_read(16'h0041, "R6 still poison after return");
    do_write(16'h0041, 8'h56);
    do_read(16'h0041, "R6 rewritten");
    do_read(16'h0005, "R6 lower kept");

    // R9: supply falls after only 2 lead edges
    for (int i = 0; i < 32; i++) do_write(16'(i), pat(i, 1));
    @(negedge clk); ram_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); supply_ok = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    check("R9 error at 2-edge lead", {7'b0, seq_err}, 8'h01);
    invalidate(0, 128);
    supply_ok = 1'b1; ram_en = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    check("R9 error sticky", {7'b0, seq_err}, 8'h01);
    sweep("R9 all lost");
    do_write(16'h0003, 8'h77);
    do_read(16'h0003, "R9 rewrite after loss");

    // R9: supply falls with enable still high
    do_reset();
    do_write(16'h0001, 8'h99);
    @(negedge clk); supply_ok = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    check("R9 error with enable high", {7'b0, seq_err}, 8'h01);
    invalidate(0, 128);
    do_read(16'h0001, "R9 low lost enable high");

    do_reset();
    @(negedge clk); #1;
    check("R5 seq_err cleared by reset", {7'b0, seq_err}, 8'h00);
    do_read(16'h0003, "R5 poison after second reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule